// File: doc/BRIEF.md
# Interrupt-Nested Condition Flag Banks

This block holds the carry, zero and sign condition flags of a processor core. It keeps one flag set for ordinary execution and another for each level of nested interrupt. The ALU and software only ever see the set that belongs to the current level. Entering an interrupt makes a new, cleared set current and leaves the interrupted set untouched. Returning from the interrupt makes the interrupted set current again. No software save or restore is needed.

The core drives the ALU flag results with a write enable, plus a one-cycle strobe for interrupt entry and one for interrupt return. The block reports the current flags, the nesting depth and two one-cycle error pulses. One pulse marks an entry refused because every level is in use. The other marks a return made with no interrupt active. The number of interrupt levels is a parameter, `NUM_LEVELS`, with a default of 4. The block therefore holds `NUM_LEVELS + 1` flag sets.

Top module: `flag_bank_stack`

## Requirements
- R1: When `alu_we` is high and neither strobe is high, the current flags (`cur_c`, `cur_z`, `cur_s`) equal the written `alu_c`, `alu_z`, `alu_s` from the next cycle on.
- R2: In a cycle with no write and no strobe, the current flags and `depth` stay unchanged.
- R3: An `irq_enter` while `depth` is below `NUM_LEVELS` raises `depth` by one. From the next cycle the current flags read C=0, Z=0, S=0.
- R4: An `irq_return` while `depth` is above zero lowers `depth` by one. The current flags then read exactly what they held before the matching entry, including values written before that entry at that level.
- R5: An `irq_enter` while `depth` equals `NUM_LEVELS` leaves `depth` and the current flags unchanged. `overflow_err` is high for the next cycle only.
- R6: An `irq_return` at depth zero leaves `depth` and the current flags unchanged. `underflow_err` is high for the next cycle only.
- R7: An ALU write in the same cycle as an accepted `irq_enter` goes to the interrupted set. The new set still reads all zeros, and the written values appear after the matching return.
- R8: An ALU write in the same cycle as an accepted `irq_return` goes to the set being left. The reinstated set is unaffected, and the next entry again reads all zeros.
- R9: When `irq_enter` and `irq_return` are both high, the entry takes priority and the return is ignored.
- R10: While `rst_n` is low, all flag sets are cleared, `depth` is 0 and both error outputs are low.
- R11: `overflow_err` and `underflow_err` are high only in the cycle after a refused entry or a refused return. `depth` never exceeds `NUM_LEVELS`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_we | input | 1 | Write the ALU flag results into the active set |
| alu_c | input | 1 | Carry result from the ALU |
| alu_z | input | 1 | Zero result from the ALU |
| alu_s | input | 1 | Sign result from the ALU |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| cur_c | output | 1 | Carry flag of the active set |
| cur_z | output | 1 | Zero flag of the active set |
| cur_s | output | 1 | Sign flag of the active set |
| depth | output | $clog2(NUM_LEVELS+1) | Current nesting depth, 0 for normal mode |
| overflow_err | output | 1 | Pulse: an entry was refused at full depth |
| underflow_err | output | 1 | Pulse: a return was refused at depth zero |

## Verification
The assertions check on every cycle the single-step properties:
- the depth moves by one on an accepted entry or return;
- a fresh set reads zeros after an entry;
- a write with no strobe becomes visible in the next cycle;
- a refused entry or return raises its error pulse, and nothing else does.

Several properties depend on history longer than one step, so only the bench's scenarios can show them:
- a set comes back intact after deeper levels have been used;
- a write made together with an entry shows up only after the matching return;
- a write made together with a return never reaches the reinstated set.

// File: rtl/flag_bank_pkg.sv
package flag_bank_pkg;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
  } cond_flags_t;

  localparam int FLAG_BITS = 3;

  // Entry is accepted only below the top level.
  function automatic logic entry_ok(input logic enter, input logic is_full);
    return enter && !is_full;
  endfunction

  // Return is accepted only when above normal mode and no entry competes.
  function automatic logic return_ok(input logic enter, input logic ret,
                                     input logic is_empty);
    return ret && !enter && !is_empty;
  endfunction

  function automatic cond_flags_t make_flags(input logic c, input logic z,
                                             input logic s);
    cond_flags_t f;
    f.c = c;
    f.z = z;
    f.s = s;
    return f;
  endfunction

endpackage

// File: rtl/fbs_level_ctrl.sv
module fbs_level_ctrl
  import flag_bank_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  localparam int DW = $clog2(NUM_LEVELS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_enter,
  input  logic          irq_return,
  output logic [DW-1:0] depth_q,
  output logic [DW-1:0] push_idx,
  output logic          push_ev,
  output logic          pop_ev,
  output logic          ovf_ev,
  output logic          unf_ev,
  output logic          ovf_q,
  output logic          unf_q
);

  localparam logic [DW-1:0] TOP_LEVEL = DW'(NUM_LEVELS);

  logic is_full;
  logic is_empty;

  assign is_full  = (depth_q == TOP_LEVEL);
  assign is_empty = (depth_q == '0);
  assign push_ev  = entry_ok(irq_enter, is_full);
  assign pop_ev   = return_ok(irq_enter, irq_return, is_empty);
  assign ovf_ev   = irq_enter && is_full;
  assign unf_ev   = irq_return && !irq_enter && is_empty;
  assign push_idx = depth_q + DW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      if (push_ev) begin
        depth_q <= push_idx;
      end else if (pop_ev) begin
        depth_q <= depth_q - DW'(1);
      end
      ovf_q <= ovf_ev;
      unf_q <= unf_ev;
    end
  end

endmodule

// File: rtl/fbs_bank_array.sv
module fbs_bank_array
  import flag_bank_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  localparam int NB = NUM_LEVELS + 1,
  localparam int DW = $clog2(NUM_LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_idx,
  input  cond_flags_t        wr_data,
  input  logic               clr_en,
  input  logic [DW-1:0]      clr_idx,
  output logic [NB*FLAG_BITS-1:0] banks_flat
);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    cond_flags_t bank_q;

    // Clearing the newly entered set and writing the interrupted set
    // always target different indices.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q <= '0;
      end else if (clr_en && (clr_idx == DW'(i))) begin
        bank_q <= '0;
      end else if (wr_en && (wr_idx == DW'(i))) begin
        bank_q <= wr_data;
      end
    end

    assign banks_flat[i*FLAG_BITS +: FLAG_BITS] = bank_q;
  end

endmodule

// File: rtl/fbs_flag_select.sv
module fbs_flag_select
  import flag_bank_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  localparam int NB = NUM_LEVELS + 1,
  localparam int DW = $clog2(NUM_LEVELS + 1)
) (
  input  logic [NB*FLAG_BITS-1:0] banks_flat,
  input  logic [DW-1:0]           sel,
  output cond_flags_t             cur
);

  always_comb begin
    cur = '0;
    for (int i = 0; i < NB; i++) begin
      if (sel == DW'(i)) begin
        cur = banks_flat[i*FLAG_BITS +: FLAG_BITS];
      end
    end
  end

endmodule

// File: rtl/flag_bank_stack.sv
module flag_bank_stack
  import flag_bank_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  localparam int NB = NUM_LEVELS + 1,
  localparam int DW = $clog2(NUM_LEVELS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alu_we,
  input  logic          alu_c,
  input  logic          alu_z,
  input  logic          alu_s,
  input  logic          irq_enter,
  input  logic          irq_return,
  output logic          cur_c,
  output logic          cur_z,
  output logic          cur_s,
  output logic [DW-1:0] depth,
  output logic          overflow_err,
  output logic          underflow_err
);

  logic [DW-1:0]           depth_q;
  logic [DW-1:0]           push_idx;
  logic                    push_ev;
  logic                    pop_ev;
  logic                    ovf_ev;
  logic                    unf_ev;
  logic                    ovf_q;
  logic                    unf_q;
  logic [NB*FLAG_BITS-1:0] banks_flat;
  cond_flags_t             wr_data;
  cond_flags_t             cur;

  assign wr_data = make_flags(alu_c, alu_z, alu_s);

  fbs_level_ctrl #(.NUM_LEVELS(NUM_LEVELS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_enter  (irq_enter),
    .irq_return (irq_return),
    .depth_q    (depth_q),
    .push_idx   (push_idx),
    .push_ev    (push_ev),
    .pop_ev     (pop_ev),
    .ovf_ev     (ovf_ev),
    .unf_ev     (unf_ev),
    .ovf_q      (ovf_q),
    .unf_q      (unf_q)
  );

  // Writes always address the set active before any switch this cycle.
  fbs_bank_array #(.NUM_LEVELS(NUM_LEVELS)) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (alu_we),
    .wr_idx     (depth_q),
    .wr_data    (wr_data),
    .clr_en     (push_ev),
    .clr_idx    (push_idx),
    .banks_flat (banks_flat)
  );

  fbs_flag_select #(.NUM_LEVELS(NUM_LEVELS)) u_sel (
    .banks_flat (banks_flat),
    .sel        (depth_q),
    .cur        (cur)
  );

  assign cur_c         = cur.c;
  assign cur_z         = cur.z;
  assign cur_s         = cur.s;
  assign depth         = depth_q;
  assign overflow_err  = ovf_q;
  assign underflow_err = unf_q;

endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
  parameter int NUM_LEVELS = 4,
  localparam int DW = $clog2(NUM_LEVELS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alu_we,
  input logic          alu_c,
  input logic          alu_z,
  input logic          alu_s,
  input logic          irq_enter,
  input logic          irq_return,
  input logic          cur_c,
  input logic          cur_z,
  input logic          cur_s,
  input logic [DW-1:0] depth,
  input logic          overflow_err,
  input logic          underflow_err,
  input logic          push_ev,
  input logic          pop_ev
);

  localparam logic [DW-1:0] TOP_LEVEL = DW'(NUM_LEVELS);

  p_write_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && !irq_enter && !irq_return)
      |=> ({cur_c, cur_z, cur_s} == $past({alu_c, alu_z, alu_s})));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_we && !irq_enter && !irq_return)
      |=> ($stable({cur_c, cur_z, cur_s}) && $stable(depth)));

  p_entry_fresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && depth != TOP_LEVEL)
      |=> (depth == $past(depth) + DW'(1) && {cur_c, cur_z, cur_s} == 3'b000));

  p_return_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_enter && depth != '0)
      |=> (depth == $past(depth) - DW'(1)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && depth == TOP_LEVEL)
      |=> (overflow_err && $stable(depth)));

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_enter && depth == '0)
      |=> (underflow_err && $stable(depth) && $stable({cur_c, cur_z, cur_s})));

  p_entry_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && irq_return) |-> !pop_ev);

  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_enter && depth == TOP_LEVEL) && !(irq_return && depth == '0)
      |=> (!overflow_err && !underflow_err));

  p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (depth <= TOP_LEVEL) && !(push_ev && pop_ev));

endmodule

bind flag_bank_stack fbs_checker #(.NUM_LEVELS(NUM_LEVELS)) u_fbs_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .alu_we        (alu_we),
  .alu_c         (alu_c),
  .alu_z         (alu_z),
  .alu_s         (alu_s),
  .irq_enter     (irq_enter),
  .irq_return    (irq_return),
  .cur_c         (cur_c),
  .cur_z         (cur_z),
  .cur_s         (cur_s),
  .depth         (depth),
  .overflow_err  (overflow_err),
  .underflow_err (underflow_err),
  .push_ev       (push_ev),
  .pop_ev        (pop_ev)
);

// File: tb/flag_bank_stack_tb_top.sv
`timescale 1ns/1ps
module flag_bank_stack_tb_top;

  localparam int LV = 4;
  localparam int DW = $clog2(LV + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          alu_we, alu_c, alu_z, alu_s;
  logic          irq_enter, irq_return;
  logic          cur_c, cur_z, cur_s;
  logic [DW-1:0] depth;
  logic          overflow_err, underflow_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  flag_bank_stack #(.NUM_LEVELS(LV)) dut_i (
    .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_c(alu_c),
    .alu_z(alu_z), .alu_s(alu_s), .irq_enter(irq_enter),
    .irq_return(irq_return), .cur_c(cur_c), .cur_z(cur_z), .cur_s(cur_s),
    .depth(depth), .overflow_err(overflow_err), .underflow_err(underflow_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Check flags {C,Z,S}, depth and the two error outputs together.
  task automatic check_state(input string req, input logic [2:0] f,
                             input int d, input logic ov, input logic un);
    check({req, " flags"}, {cur_c, cur_z, cur_s}, f);
    check({req, " depth"}, depth, d);
    check({req, " ovf"}, overflow_err, ov);
    check({req, " unf"}, underflow_err, un);
  endtask

  // Drive one cycle at the falling edge, return at the next falling edge.
  task automatic step(input logic we, input logic [2:0] f,
                      input logic en, input logic ret);
    alu_we = we; {alu_c, alu_z, alu_s} = f;
    irq_enter = en; irq_return = ret;
    @(posedge clk);
    @(negedge clk);
    alu_we = 0; irq_enter = 0; irq_return = 0; {alu_c, alu_z, alu_s} = 3'b000;
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(0, 3'b000, 0, 0);
    step(0, 3'b000, 0, 0);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    check_state("R10 after reset", 3'b000, 0, 0, 0);
  endtask

  task automatic t_write_hold();
    step(1, 3'b101, 0, 0);
    check_state("R1 write", 3'b101, 0, 0, 0);
    step(1, 3'b010, 0, 0);
    check_state("R1 rewrite", 3'b010, 0, 0, 0);
    step(0, 3'b111, 0, 0);
    step(0, 3'b000, 0, 0);
    check_state("R2 hold", 3'b010, 0, 0, 0);
  endtask

  task automatic t_nest_restore();
    logic [2:0] pat [LV];
    pat[0] = 3'b101; pat[1] = 3'b011; pat[2] = 3'b110; pat[3] = 3'b001;
    step(1, pat[0], 0, 0);
    for (int i = 1; i <= LV; i++) begin
      step(0, 3'b000, 1, 0);
      check_state("R3 entry", 3'b000, i, 0, 0);
      if (i < LV) step(1, pat[i], 0, 0);
    end
    step(1, 3'b111, 0, 0);
    check_state("R1 top level write", 3'b111, LV, 0, 0);
    step(0, 3'b000, 1, 0);
    check_state("R5 overflow", 3'b111, LV, 1, 0);
    step(0, 3'b000, 0, 0);
    check_state("R11 overflow pulse ends", 3'b111, LV, 0, 0);
    for (int i = LV - 1; i >= 0; i--) begin
      step(0, 3'b000, 0, 1);
      check_state("R4 restore", pat[i], i, 0, 0);
    end
    step(0, 3'b000, 0, 1);
    check_state("R6 underflow", pat[0], 0, 0, 1);
    step(0, 3'b000, 0, 0);
    check_state("R11 underflow pulse ends", pat[0], 0, 0, 0);
  endtask

  task automatic t_write_on_entry();
    step(1, 3'b100, 0, 0);
    step(1, 3'b010, 1, 0);
    check_state("R7 new set clear", 3'b000, 1, 0, 0);
    step(0, 3'b000, 0, 1);
    check_state("R7 old set got write", 3'b010, 0, 0, 0);
  endtask

  task automatic t_write_on_return();
    step(0, 3'b000, 1, 0);
    step(1, 3'b111, 0, 0);
    step(1, 3'b001, 0, 1);
    check_state("R8 restored set unaffected", 3'b010, 0, 0, 0);
    step(0, 3'b000, 1, 0);
    check_state("R8 re-entry clear", 3'b000, 1, 0, 0);
  endtask

  task automatic t_both_strobes();
    step(1, 3'b110, 0, 0);
    step(0, 3'b000, 1, 1);
    check_state("R9 entry wins", 3'b000, 2, 0, 0);
    step(0, 3'b000, 0, 1);
    check_state("R9 lower set intact", 3'b110, 1, 0, 0);
    step(0, 3'b000, 0, 1);
    check_state("R9 back to normal", 3'b010, 0, 0, 0);
  endtask

  task automatic t_reset_midway();
    step(1, 3'b111, 0, 0);
    step(0, 3'b000, 1, 0);
    step(1, 3'b101, 0, 0);
    do_reset();
    check_state("R10 reset while nested", 3'b000, 0, 0, 0);
    step(0, 3'b000, 1, 0);
    step(0, 3'b000, 0, 1);
    check_state("R10 banks cleared", 3'b000, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; alu_we = 0; alu_c = 0; alu_z = 0; alu_s = 0;
    irq_enter = 0; irq_return = 0;
    @(negedge clk);
    t_reset();
    t_write_hold();
    t_nest_restore();
    t_write_on_entry();
    t_write_on_return();
    t_both_strobes();
    t_reset_midway();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule